// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Generator

This block drives several PWM outputs from one common time base. A single counter and a single period limit (`top`) are shared by every channel. Each channel holds its own compare value, an active bit and an invert bit. The counter moves only on a tick produced by two dividers in series.

Two counting modes are offered. In edge-aligned mode the counter counts from 0 up to `top`, then wraps. In center-aligned mode it counts up to `top`, then back down to 0, and each channel's pulse sits in the middle of the period. Software programs the block through a one-cycle register write port. Every accepted or rejected write halts the counter and clears it. Counting resumes on the next cycle if the enable bit is set. The live count is always visible on `count_o`.

The counter is a three-state machine:
- HALT: the count is held at 0.
- UP: the counter counts up.
- DOWN: the counter counts down.

Its transitions are:
- CLEAR: any state goes to HALT on a write, or when enable is low.
- START: HALT goes to UP when enable is set.
- WRAP: UP stays in UP and returns to 0 at `top`, in edge mode.
- TURN: UP goes to DOWN at `top`, in center mode.
- RETURN: DOWN goes to UP on reaching 0.

Register addresses on `wr_addr_i`:
- `0x00` is control. Bit 0 is enable. Bit 1 selects center mode (1) or edge mode (0).
- `0x01` is the tick divider and `0x02` is the prescaler, each in data bits [7:0].
- `0x03` is `top`.
- `0x10+n` is the compare value of channel n.
- `0x20+n` is the attributes of channel n. Bit 0 is active and bit 1 is invert.

Top module: `pwm_shared_ctr`

## Requirements
- R1: The counter changes only on a tick. With divider D at address 0x01 and prescaler P at address 0x02, a tick comes once every (D+1)*(P+1) clocks.
- R2: In edge mode (control bit 1 = 0), the counter runs 0,1,...,top and then returns to 0. The period is top+1 ticks, and the count never exceeds top.
- R3: In center mode (control bit 1 = 1, top >= 1), the counter runs 0 up to top and then down to 1. The period is 2*top ticks.
- R4: An active, non-inverted channel is high while count < compare. With 0 < compare < top, it is high for compare ticks per period in edge mode and 2*compare-1 ticks in center mode. `pwm_o` follows the count with one clock of latency.
- R5: A compare of 0 gives a constant low output. A compare of top or more gives a constant high output in both modes.
- R6: Setting invert (attribute bit 1) complements an active channel's output. A channel whose active bit (attribute bit 0) is clear drives 0, whatever its invert bit.
- R7: Any write clears the count to 0 and puts the counter in HALT. The counter starts counting on the following cycle only if control bit 0 is set; otherwise the count stays 0. After reset the count, all outputs and both error flags are 0.
- R8: A compare write whose data exceeds the current top is rejected. The stored compare is unchanged, and `err_range_o` pulses high for one cycle, in the cycle after the write.
- R9: While any channel is active, a write to top is rejected, top is unchanged and `err_lock_o` pulses for one cycle after the write. Once every channel is inactive, top can be written again.
- R10: Writes act at once, with no shadow register. `count_o` shows the live count: the first tick comes two cycles after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 6 | Register address |
| wr_data_i | input | CW | Register write data |
| count_o | output | CW | Live counter value |
| pwm_o | output | NCH | Channel outputs |
| err_range_o | output | 1 | One-cycle pulse: a compare write was rejected because it exceeds top |
| err_lock_o | output | 1 | One-cycle pulse: a top write was rejected because top is locked |

## Verification
The scoreboard measures whole periods in clocks and the high time of a chosen channel, so each expectation is a pair of (period, high count).

The corner cases and the failure each one exposes:
- Compare at 0 and compare at top: an off-by-one comparator would leave a one-tick glitch in what should be a flat line.
- Center-mode turnaround: a counter that repeats `top` or 0 at the turn stretches the period past 2*top.
- The inverted channel and an inverted but inactive channel: these catch polarity handled in the wrong order relative to the active gating.
- Rejected compare and top writes: a design that stores the value anyway shows a changed duty or period.
- Divider and prescaler: if the dividers are chained wrongly, the period is no longer the product (D+1)*(P+1) times the tick count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_DIV  = 6'h01;
    localparam logic [ADDR_W-1:0] A_PRE  = 6'h02;
    localparam logic [ADDR_W-1:0] A_TOP  = 6'h03;

    localparam logic [1:0] SEL_CMP  = 2'b01;
    localparam logic [1:0] SEL_ATTR = 2'b10;

    typedef enum logic [1:0] {
        CS_HALT = 2'd0,
        CS_UP   = 2'd1,
        CS_DOWN = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [DW-1:0] div_i,
    input  logic [DW-1:0] pre_i,
    output logic          tick_o
);
    logic [DW-1:0] div_cnt_q;
    logic [DW-1:0] pre_cnt_q;
    logic          div_hit;
    logic          pre_hit;

    assign div_hit = (div_cnt_q == div_i);
    assign pre_hit = (pre_cnt_q == pre_i);
    assign tick_o  = run_i && !clr_i && div_hit && pre_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
            pre_cnt_q <= '0;
        end else if (clr_i || !run_i) begin
            div_cnt_q <= '0;
            pre_cnt_q <= '0;
        end else if (div_hit) begin
            div_cnt_q <= '0;
            pre_cnt_q <= pre_hit ? '0 : pre_cnt_q + 1'b1;
        end else begin
            div_cnt_q <= div_cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (div_i != '0 || pre_i != '0) && $stable(div_i) && $stable(pre_i)) |=> !tick_o) // R1
        else $error("tick repeated with a divide ratio above one");
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          center_i,
    input  logic          tick_i,
    input  logic [CW-1:0] top_i,
    output logic [CW-1:0] cnt_o,
    output cnt_state_e    state_o
);
    cnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions and count update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr_i) begin
            state_d = CS_HALT;          // CLEAR
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CS_HALT: begin
                    if (en_i) state_d = CS_UP;   // START
                end
                CS_UP: begin
                    if (!en_i) begin
                        state_d = CS_HALT;
                        cnt_d   = '0;
                    end else if (tick_i) begin
                        if (cnt_q >= top_i) begin
                            if (center_i && top_i != '0) begin
                                cnt_d   = top_i - 1'b1;        // TURN
                                state_d = (top_i > 1) ? CS_DOWN : CS_UP;
                            end else begin
                                cnt_d = '0;                    // WRAP
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                CS_DOWN: begin
                    if (!en_i) begin
                        state_d = CS_HALT;
                        cnt_d   = '0;
                    end else if (tick_i) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q <= 1) state_d = CS_UP;       // RETURN
                    end
                end
                default: begin
                    state_d = CS_HALT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign state_o = state_q;

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i && en_i) |=> $stable(cnt_q)) // R1
        else $error("count moved without a tick");
    AST_CLEAR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && state_q == CS_HALT)) // R7
        else $error("write did not clear and halt the counter");
    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_UP && tick_i && en_i && !clr_i && !center_i && cnt_q == top_i) |=> cnt_q == '0) // R2
        else $error("edge mode did not wrap at top");
    AST_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= top_i) // R2
        else $error("count above top");
    AST_CENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_UP && tick_i && en_i && !clr_i && center_i && top_i > 1 && cnt_q == top_i)
        |=> (state_q == CS_DOWN && cnt_q == $past(top_i) - 1'b1)) // R3
        else $error("center mode did not turn at top");
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] top_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          active_i,
    input  logic          inv_i,
    output logic          pwm_o
);
    logic level;
    logic out_q;

    // high from the zero point until the compare match; reversed order on the
    // way down yields the same level, so the pulse is centred in that mode
    always_comb begin
        if (cmp_i == '0)        level = 1'b0;
        else if (cmp_i >= top_i) level = 1'b1;
        else                    level = (cnt_i < cmp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= active_i & (level ^ inv_i);
    end

    assign pwm_o = out_q;

    AST_INACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !pwm_o) // R6
        else $error("inactive channel driven high");
    AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !inv_i && cmp_i == '0) |=> !pwm_o) // R5
        else $error("compare of zero gave a high output");
    AST_FULL_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !inv_i && cmp_i != '0 && cmp_i == top_i) |=> pwm_o) // R5
        else $error("compare at top gave a low output");
endmodule

// File: rtl/pwm_cfg.sv
module pwm_cfg
    import pwm_pkg::*;
#(
    parameter int NCH = 10,
    parameter int CW  = 32,
    parameter int DW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [CW-1:0]            wr_data_i,
    output logic                     clr_o,
    output logic                     en_o,
    output logic                     center_o,
    output logic [DW-1:0]            div_o,
    output logic [DW-1:0]            pre_o,
    output logic [CW-1:0]            top_o,
    output logic [NCH-1:0][CW-1:0]   cmp_o,
    output logic [NCH-1:0]           active_o,
    output logic [NCH-1:0]           inv_o,
    output logic                     err_range_o,
    output logic                     err_lock_o
);
    logic [IDX_W-1:0]        idx;
    logic [1:0]              sel;
    logic                    ch_ok;
    logic                    locked;
    logic                    is_top_wr;
    logic                    is_cmp_wr;
    logic                    cmp_bad;

    logic                    en_q, center_q;
    logic [DW-1:0]           div_q, pre_q;
    logic [CW-1:0]           top_q;
    logic [NCH-1:0][CW-1:0]  cmp_q;
    logic [NCH-1:0]          active_q, inv_q;
    logic                    err_range_q, err_lock_q;

    assign idx       = wr_addr_i[IDX_W-1:0];
    assign sel       = wr_addr_i[ADDR_W-1:IDX_W];
    assign ch_ok     = (32'(idx) < NCH);
    assign locked    = |active_q;
    assign is_top_wr = wr_en_i && (wr_addr_i == A_TOP);
    assign is_cmp_wr = wr_en_i && (sel == SEL_CMP) && ch_ok;
    assign cmp_bad   = (wr_data_i > top_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            center_q    <= 1'b0;
            div_q       <= '0;
            pre_q       <= '0;
            top_q       <= '0;
            cmp_q       <= '0;
            active_q    <= '0;
            inv_q       <= '0;
            err_range_q <= 1'b0;
            err_lock_q  <= 1'b0;
        end else begin
            err_range_q <= 1'b0;
            err_lock_q  <= 1'b0;
            if (wr_en_i) begin
                if (wr_addr_i == A_CTRL) begin
                    en_q     <= wr_data_i[0];
                    center_q <= wr_data_i[1];
                end else if (wr_addr_i == A_DIV) begin
                    div_q <= wr_data_i[DW-1:0];
                end else if (wr_addr_i == A_PRE) begin
                    pre_q <= wr_data_i[DW-1:0];
                end else if (wr_addr_i == A_TOP) begin
                    if (locked) err_lock_q <= 1'b1;
                    else        top_q      <= wr_data_i;
                end else if (sel == SEL_CMP && ch_ok) begin
                    if (cmp_bad) err_range_q <= 1'b1;
                    else         cmp_q[idx]  <= wr_data_i;
                end else if (sel == SEL_ATTR && ch_ok) begin
                    active_q[idx] <= wr_data_i[0];
                    inv_q[idx]    <= wr_data_i[1];
                end
            end
        end
    end

    assign clr_o       = wr_en_i;
    assign en_o        = en_q;
    assign center_o    = center_q;
    assign div_o       = div_q;
    assign pre_o       = pre_q;
    assign top_o       = top_q;
    assign cmp_o       = cmp_q;
    assign active_o    = active_q;
    assign inv_o       = inv_q;
    assign err_range_o = err_range_q;
    assign err_lock_o  = err_lock_q;

    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp_wr && cmp_bad) |=> (err_range_o && $stable(cmp_q))) // R8
        else $error("out-of-range compare accepted");
    AST_TOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_top_wr && locked) |=> (err_lock_o && $stable(top_q))) // R9
        else $error("top changed while locked");
    AST_TOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_top_wr && !locked) |=> (!err_lock_o && top_q == $past(wr_data_i))) // R9
        else $error("unlocked top write not taken");
endmodule

// File: rtl/pwm_shared_ctr.sv
module pwm_shared_ctr
    import pwm_pkg::*;
#(
    parameter int NCH = 10,
    parameter int CW  = 32,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [5:0]        wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    output logic [CW-1:0]     count_o,
    output logic [NCH-1:0]    pwm_o,
    output logic              err_range_o,
    output logic              err_lock_o
);
    logic                    clr, en, center, tick, run;
    logic [DW-1:0]           div_v, pre_v;
    logic [CW-1:0]           top_v, cnt;
    logic [NCH-1:0][CW-1:0]  cmp_v;
    logic [NCH-1:0]          active_v, inv_v;
    cnt_state_e              state;

    pwm_cfg #(.NCH(NCH), .CW(CW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .clr_o(clr), .en_o(en), .center_o(center),
        .div_o(div_v), .pre_o(pre_v), .top_o(top_v), .cmp_o(cmp_v),
        .active_o(active_v), .inv_o(inv_v),
        .err_range_o(err_range_o), .err_lock_o(err_lock_o)
    );

    assign run = (state != CS_HALT);

    pwm_tick_gen #(.DW(DW)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(run),
        .div_i(div_v), .pre_i(pre_v), .tick_o(tick)
    );

    pwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .center_i(center),
        .tick_i(tick), .top_i(top_v), .cnt_o(cnt), .state_o(state)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .top_i(top_v),
            .cmp_i(cmp_v[g]), .active_i(active_v[g]), .inv_i(inv_v[g]),
            .pwm_o(pwm_o[g])
        );
    end

    assign count_o = cnt;
endmodule

// File: tb/test_pwm_shared_ctr.sv
module test_pwm_shared_ctr;
    localparam int NCH = 10;
    localparam int CW  = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wr_en;
    logic [5:0]     wr_addr;
    logic [CW-1:0]  wr_data;
    logic [CW-1:0]  count_o;
    logic [NCH-1:0] pwm_o;
    logic           err_range_o, err_lock_o;

    int errs   = 0;
    int checks = 0;

    typedef struct {
        int rq;
        int ch;
        int per;
        int hi;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pwm_shared_ctr #(.NCH(NCH), .CW(CW)) i_pwm_shared_ctr (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .count_o(count_o), .pwm_o(pwm_o),
        .err_range_o(err_range_o), .err_lock_o(err_lock_o)
    );

    task automatic chk(input bit ok, input int rq, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL R%0d %s: got %0d expected %0d", rq, what, act, expv);
        end
    endtask

    // returns at the negedge after the write edge, where pulses are visible
    task automatic wr(input logic [5:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver: push an expected (period, high) pair and wait for the monitor
    task automatic expect_wave(input int rq, input int ch, input int per, input int hi);
        exp_t e;
        e.rq = rq; e.ch = ch; e.per = per; e.hi = hi;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    // monitor: sync to a fresh zero of the count, then measure one period
    initial begin
        exp_t        e;
        int          n;
        int          h;
        logic [CW-1:0] prev;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q[0];
            prev = count_o;
            forever begin
                @(negedge clk);
                if (count_o == '0 && prev != '0) break;
                prev = count_o;
            end
            n = 1;
            h = int'(pwm_o[e.ch]);
            prev = '0;
            forever begin
                @(negedge clk);
                if (count_o == '0 && prev != '0) break;
                n++;
                h += int'(pwm_o[e.ch]);
                prev = count_o;
            end
            chk(n == e.per, e.rq, $sformatf("period clocks ch%0d", e.ch), n, e.per);
            chk(h == e.hi,  e.rq, $sformatf("high clocks ch%0d", e.ch), h, e.hi);
            exp_q.delete(0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(count_o == '0, 7, "reset count", count_o, 0);
        chk(pwm_o == '0, 7, "reset outputs", pwm_o, 0);
        chk(!err_range_o && !err_lock_o, 7, "reset flags", {err_range_o, err_lock_o}, 0);
        rst_n = 1'b1;

        // top = 9, four active channels plus one inverted but inactive channel
        wr(6'h03, 9);
        wr(6'h10, 0);
        wr(6'h11, 9);
        wr(6'h12, 4);
        wr(6'h13, 4);
        wr(6'h14, 4);
        wr(6'h20, 1);
        wr(6'h21, 1);
        wr(6'h22, 1);
        wr(6'h23, 3);
        wr(6'h24, 2);
        wr(6'h01, 0);
        wr(6'h02, 0);
        wr(6'h00, 1);
        chk(count_o == '0, 7, "count right after write", count_o, 0);          // R7
        repeat (3) @(negedge clk);
        chk(count_o == 2, 10, "live count two ticks after start", count_o, 2); // R10

        // edge mode: period top+1
        expect_wave(5, 0, 10, 0);   // R5 compare 0
        expect_wave(5, 1, 10, 10);  // R5 compare = top
        expect_wave(4, 2, 10, 4);   // R4 midpoint, also R2 period
        expect_wave(6, 3, 10, 6);   // R6 inverted
        expect_wave(6, 4, 10, 0);   // R6 inactive + invert stays low

        // center mode: period 2*top
        wr(6'h00, 3);
        expect_wave(5, 0, 18, 0);   // R5
        expect_wave(5, 1, 18, 18);  // R5
        expect_wave(3, 2, 18, 7);   // R3 period, R4 2*cmp-1
        expect_wave(6, 3, 18, 11);  // R6

        // R8: compare above top rejected
        wr(6'h12, 20);
        chk(err_range_o == 1'b1, 8, "range error pulse", err_range_o, 1);
        chk(err_lock_o == 1'b0, 8, "no lock error on compare", err_lock_o, 0);
        @(negedge clk);
        chk(err_range_o == 1'b0, 8, "range pulse one cycle", err_range_o, 0);
        expect_wave(8, 2, 18, 7);   // R8 compare unchanged

        // R9: top locked while channels active
        wr(6'h03, 5);
        chk(err_lock_o == 1'b1, 9, "lock error pulse", err_lock_o, 1);
        expect_wave(9, 1, 18, 18);  // R9 top unchanged

        wr(6'h20, 0);
        wr(6'h21, 0);
        wr(6'h22, 0);
        wr(6'h23, 0);
        wr(6'h03, 5);
        chk(err_lock_o == 1'b0, 9, "top accepted after release", err_lock_o, 0);
        wr(6'h12, 2);
        wr(6'h22, 1);
        wr(6'h00, 1);
        expect_wave(2, 2, 6, 2);    // R2 new top in edge mode

        // R7: enable clear keeps the count at zero
        wr(6'h00, 0);
        repeat (20) @(negedge clk);
        chk(count_o == '0, 7, "count held while disabled", count_o, 0);

        // R1: divider 2, prescaler 1 -> 6 clocks per tick
        wr(6'h01, 2);
        wr(6'h02, 1);
        wr(6'h00, 1);
        expect_wave(1, 2, 36, 12);  // R1

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule